// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block turns a 3-bit addressing mode, a 3-bit register number and a byte/word flag into the effective address of one operand. It is built for a 16-bit machine with eight general registers, where register 6 is the stack pointer and register 7 is the program counter. The block reads an external register file through one combinational read port. It writes back any register that the mode changes. It fetches index words and deferred pointers over a memory read port with a valid/ready handshake.

A request is a one-cycle `start` pulse with `mode`, `reg_sel` and `byte_op` held valid in that cycle. When the sequencer finishes, it raises `done` for exactly one cycle. At that point `eff_addr` holds the operand address, or `is_reg` says that the operand is the register itself. Both outputs keep their values until the next request. The data access that follows is left to the caller. `start` is only looked at while the sequencer is idle.

Top module: `opas_addr_seq`

## Requirements
- R1: Mode 0 completes with `is_reg` = 1 and `eff_addr` equal to the register number zero-extended. It makes no memory read and no register write.
- R2: Mode 1 returns the register contents as the address. It makes no memory read and no register write.
- R3: Mode 2 returns the register's old value as the address, then adds a step to the register. The step is 1 for a byte (`byte_op` = 1) on registers 0 to 5. It is 2 for a word, and 2 for any access through register 6 or 7.
- R4: Mode 3 reads a word at the register's old value and returns that word as the address. The register then grows by 2 in both byte and word mode.
- R5: Mode 4 lowers the register by the step rule of R3 and returns the lowered value as the address.
- R6: Mode 5 lowers the register by 2, reads a word at the lowered value and returns that word as the address.
- R7: Mode 6 reads an index word at the value of register 7 and writes register 7 back increased by 2. It returns base plus index, where the base is the selected register. When the selected register is register 7, the base is its value after the increase.
- R8: Mode 7 computes base plus index in the same way as R7, including the register 7 update. It then reads a word at that sum and returns the word as the address.
- R9: All address and register arithmetic wraps modulo 2^16.
- R10: Modes 2 to 7 write exactly one register, in one `rf_we` cycle. Modes 0 and 1 write none. `done` is high for one cycle, and `eff_addr` does not change in the cycle after it.
- R11: With `mem_rd_ready` held high, `done` is high in cycle N after the cycle in which `start` is sampled. N is 2 for modes 0 and 1, 3 for modes 2 and 4, 4 for modes 3 and 5, 5 for mode 6 and 6 for mode 7. Each cycle of a stalled read adds one cycle.
- R12: While `mem_rd_valid` is high and `mem_rd_ready` is low, the request stays up and `mem_rd_addr` stays unchanged. A stalled read produces the same result as an unstalled one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a resolution (sampled when idle) |
| mode | input | 3 | Addressing mode 0..7 |
| reg_sel | input | 3 | Register number |
| byte_op | input | 1 | 1 = byte operand, 0 = word operand |
| done | output | 1 | One-cycle completion pulse |
| is_reg | output | 1 | Operand is the register itself |
| eff_addr | output | 16 | Effective address (register number in mode 0) |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory accepts request; data valid in same cycle |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 16 | Memory read data |

## Verification
Each request is driven at a falling edge and sampled at the next rising edge. The bench then counts falling edges until `done` is seen. With the read port always ready, that count must be 2, 3, 4, 5 or 6 depending on the mode. The address, register file contents, write-back count and memory handshake count are checked at that same falling edge. One edge later the bench checks that `done` has fallen and `eff_addr` has held its value. In the stalled runs the ready signal is high only one cycle in four. Those runs compare only the results, not the cycle count, and require that the count grew past the unstalled value.

// File: rtl/opas_pkg.sv
// Shared types for the operand addressing mode sequencer.
// Assumes a 3-bit mode encoding whose values are fixed by the instruction format.
package opas_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RDREG = 3'd1,
        ST_RDPC  = 3'd2,
        ST_IDX   = 3'd3,
        ST_PTR   = 3'd4,
        ST_WB    = 3'd5,
        ST_DONE  = 3'd6
    } opas_state_e;

    // Addressing modes; the numeric values are decoded from the instruction
    typedef enum logic [2:0] {
        AM_REG      = 3'd0,
        AM_IND      = 3'd1,
        AM_POST     = 3'd2,
        AM_POST_DEF = 3'd3,
        AM_PRE      = 3'd4,
        AM_PRE_DEF  = 3'd5,
        AM_IDX      = 3'd6,
        AM_IDX_DEF  = 3'd7
    } opas_mode_e;

endpackage

// File: rtl/opas_step_calc.sv
// Step size for register auto-increment and auto-decrement.
// Assumes registers SP_IDX and PC_IDX must stay word aligned.
// Only the plain post-increment and pre-decrement modes can step by one.
module opas_step_calc
    import opas_pkg::*;
#(
    parameter int AW     = 16,
    parameter int RW     = 3,
    parameter int SP_IDX = 6,
    parameter int PC_IDX = 7
) (
    input  opas_mode_e      mode,
    input  logic [RW-1:0]   reg_idx,
    input  logic            byte_op,
    output logic [AW-1:0]   step
);
    localparam logic [AW-1:0] STEP_BYTE = AW'(1);
    localparam logic [AW-1:0] STEP_WORD = AW'(2);

    logic aligned_reg;
    logic step_mode;

    // Pick byte or word stepping from mode, register and operand size
    always_comb begin
        aligned_reg = (reg_idx == RW'(SP_IDX)) || (reg_idx == RW'(PC_IDX));
        step_mode   = (mode == AM_POST) || (mode == AM_PRE);
        step        = (step_mode && byte_op && !aligned_reg) ? STEP_BYTE : STEP_WORD;
    end
endmodule

// File: rtl/opas_addr_alu.sv
// Modulo 2^AW adder/subtractor used for register stepping and indexing.
// Assumes no carry or borrow is needed outside the block.
module opas_addr_alu #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic          sub,
    output logic [AW-1:0] y
);
    // Wrap-around add or subtract
    always_comb begin
        y = sub ? (a - b) : (a + b);
    end
endmodule

// File: rtl/opas_addr_seq.sv
// Operand addressing mode sequencer (top).
// Resolves one operand address per start pulse.
// Reads the register file combinationally and fetches index words and
// pointers over a valid/ready read port, where data arrives in the
// accepting cycle. Writes back at most one register.
// Assumes start is asserted only while idle; starts seen while busy are ignored.
module opas_addr_seq
    import opas_pkg::*;
#(
    parameter int AW     = 16,
    parameter int RW     = 3,
    parameter int SP_IDX = 6,
    parameter int PC_IDX = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [RW-1:0] reg_sel,
    input  logic          byte_op,
    output logic          done,
    output logic          is_reg,
    output logic [AW-1:0] eff_addr,
    output logic [RW-1:0] rf_raddr,
    input  logic [AW-1:0] rf_rdata,
    output logic          rf_we,
    output logic [RW-1:0] rf_waddr,
    output logic [AW-1:0] rf_wdata,
    output logic          mem_rd_valid,
    input  logic          mem_rd_ready,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [AW-1:0] mem_rd_data
);
    localparam logic [RW-1:0] PC_SEL = RW'(PC_IDX);

    opas_state_e   state_q;
    opas_mode_e    mode_q;
    logic [RW-1:0] reg_q;
    logic          byte_q;
    logic [AW-1:0] rval_q;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] ptr_q;
    logic [RW-1:0] wb_idx_q;
    logic [AW-1:0] wb_val_q;
    logic [AW-1:0] addr_q;
    logic          isreg_q;

    logic [AW-1:0] step;
    logic          step_sub;
    logic [AW-1:0] stepped;
    logic [AW-1:0] idx_base;
    logic [AW-1:0] idx_sum;
    logic          rd_fire;

    // Step size from the latched request
    opas_step_calc #(
        .AW(AW), .RW(RW), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)
    ) u_step (
        .mode    (mode_q),
        .reg_idx (reg_q),
        .byte_op (byte_q),
        .step    (step)
    );

    // Register stepping: pre-decrement modes subtract, all others add.
    // In ST_RDPC the same adder yields PC + 2.
    always_comb begin
        step_sub = (mode_q == AM_PRE) || (mode_q == AM_PRE_DEF);
    end

    opas_addr_alu #(.AW(AW)) u_step_alu (
        .a   (rf_rdata),
        .b   (step),
        .sub (step_sub),
        .y   (stepped)
    );

    // Index base: the advanced PC when the program counter is selected
    always_comb begin
        idx_base = (reg_q == PC_SEL) ? wb_val_q : rval_q;
    end

    opas_addr_alu #(.AW(AW)) u_idx_alu (
        .a   (idx_base),
        .b   (mem_rd_data),
        .sub (1'b0),
        .y   (idx_sum)
    );

    // Port drive decoded from the state register
    always_comb begin
        rf_raddr     = (state_q == ST_RDPC) ? PC_SEL : reg_q;
        rf_we        = (state_q == ST_WB);
        rf_waddr     = wb_idx_q;
        rf_wdata     = wb_val_q;
        mem_rd_valid = (state_q == ST_IDX) || (state_q == ST_PTR);
        mem_rd_addr  = (state_q == ST_IDX) ? pc_q : ptr_q;
        rd_fire      = mem_rd_valid && mem_rd_ready;
        done         = (state_q == ST_DONE);
        is_reg       = isreg_q;
        eff_addr     = addr_q;
    end

    // Sequencer state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= AM_REG;
            reg_q    <= '0;
            byte_q   <= 1'b0;
            rval_q   <= '0;
            pc_q     <= '0;
            ptr_q    <= '0;
            wb_idx_q <= '0;
            wb_val_q <= '0;
            addr_q   <= '0;
            isreg_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= opas_mode_e'(mode);
                        reg_q   <= reg_sel;
                        byte_q  <= byte_op;
                        isreg_q <= 1'b0;
                        state_q <= ST_RDREG;
                    end
                end
                ST_RDREG: begin
                    rval_q <= rf_rdata;
                    case (mode_q)
                        AM_REG: begin
                            addr_q  <= {{(AW-RW){1'b0}}, reg_q};
                            isreg_q <= 1'b1;
                            state_q <= ST_DONE;
                        end
                        AM_IND: begin
                            addr_q  <= rf_rdata;
                            state_q <= ST_DONE;
                        end
                        AM_POST: begin
                            addr_q   <= rf_rdata;
                            wb_idx_q <= reg_q;
                            wb_val_q <= stepped;
                            state_q  <= ST_WB;
                        end
                        AM_POST_DEF: begin
                            ptr_q    <= rf_rdata;
                            wb_idx_q <= reg_q;
                            wb_val_q <= stepped;
                            state_q  <= ST_PTR;
                        end
                        AM_PRE: begin
                            addr_q   <= stepped;
                            wb_idx_q <= reg_q;
                            wb_val_q <= stepped;
                            state_q  <= ST_WB;
                        end
                        AM_PRE_DEF: begin
                            ptr_q    <= stepped;
                            wb_idx_q <= reg_q;
                            wb_val_q <= stepped;
                            state_q  <= ST_PTR;
                        end
                        default: begin
                            state_q <= ST_RDPC;
                        end
                    endcase
                end
                ST_RDPC: begin
                    pc_q     <= rf_rdata;
                    wb_idx_q <= PC_SEL;
                    wb_val_q <= stepped;
                    state_q  <= ST_IDX;
                end
                ST_IDX: begin
                    if (rd_fire) begin
                        if (mode_q == AM_IDX) begin
                            addr_q  <= idx_sum;
                            state_q <= ST_WB;
                        end else begin
                            ptr_q   <= idx_sum;
                            state_q <= ST_PTR;
                        end
                    end
                end
                ST_PTR: begin
                    if (rd_fire) begin
                        addr_q  <= mem_rd_data;
                        state_q <= ST_WB;
                    end
                end
                ST_WB: begin
                    state_q <= ST_DONE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/opas_addr_seq_chk.sv
// Protocol checker for the operand addressing mode sequencer, bound to the top.
// Observes ports only.
module opas_addr_seq_chk #(
    parameter int AW = 16,
    parameter int RW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          is_reg,
    input logic [AW-1:0] eff_addr,
    input logic          rf_we,
    input logic          mem_rd_valid,
    input logic          mem_rd_ready,
    input logic [AW-1:0] mem_rd_addr
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(eff_addr));

    // R10
    single_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R10
    quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rf_we && !mem_rd_valid));

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R1
    reg_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_reg) |-> (eff_addr < AW'(1 << RW)));
endmodule

bind opas_addr_seq opas_addr_seq_chk #(.AW(AW), .RW(RW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done         (done),
    .is_reg       (is_reg),
    .eff_addr     (eff_addr),
    .rf_we        (rf_we),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr)
);

// File: tb/sim_opas_addr_seq.sv
`timescale 1ns/1ps
// Directed bench for opas_addr_seq: one task per scenario.
module sim_opas_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  reg_sel = '0;
    logic        byte_op = 1'b0;
    logic        done, is_reg;
    logic [15:0] eff_addr;
    logic [2:0]  rf_raddr, rf_waddr;
    logic [15:0] rf_rdata, rf_wdata;
    logic        rf_we;
    logic        mem_rd_valid, mem_rd_ready;
    logic [15:0] mem_rd_addr, mem_rd_data;

    logic [15:0] rf [8];
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [15:0] ld_val = '0;
    logic        stall_en = 1'b0;
    logic [1:0]  tick = '0;
    int          wb_cnt = 0;
    int          rd_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always #2 clk = ~clk;

    opas_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_sel(reg_sel),
        .byte_op(byte_op), .done(done), .is_reg(is_reg), .eff_addr(eff_addr),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
    );

    // Memory content as a pure function of the address
    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0], a[15:8]} + 16'h0101;
    endfunction

    assign rf_rdata     = rf[rf_raddr];
    assign mem_rd_data  = memf(mem_rd_addr);
    assign mem_rd_ready = !stall_en || (tick == 2'd0);

    // Register file model, event counters and watchdog
    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tick <= tick + 2'd1;
        if (rf_we) begin
            rf[rf_waddr] <= rf_wdata;
            wb_cnt <= wb_cnt + 1;
        end else if (ld_en) begin
            rf[ld_idx] <= ld_val;
        end
        if (mem_rd_valid && mem_rd_ready) rd_cnt <= rd_cnt + 1;
        if (cyc == 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_reg(input int i, input logic [15:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 3'(i); ld_val = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Run one resolution and check every result against the requirement model
    task automatic run_case(input int m, input int r, input bit byt, input bit stall, input string tag);
        logic [15:0] snap [8];
        logic [15:0] ex_addr, step, base, pcn, ex_val;
        int ex_wb, ex_rd, ex_lat, ex_reg, lat;
        bit ex_isreg;
        for (int i = 0; i < 8; i++) snap[i] = rf[i];
        step = (((m == 2) || (m == 4)) && byt && (r < 6)) ? 16'd1 : 16'd2;
        pcn  = snap[7] + 16'd2;
        base = (r == 7) ? pcn : snap[r];
        ex_isreg = 1'b0; ex_reg = r; ex_val = snap[r]; ex_wb = 1; ex_rd = 0;
        case (m)
            0: begin ex_isreg = 1'b1; ex_addr = 16'(r); ex_wb = 0; ex_lat = 2; end
            1: begin ex_addr = snap[r]; ex_wb = 0; ex_lat = 2; end
            2: begin ex_addr = snap[r]; ex_val = snap[r] + step; ex_lat = 3; end
            3: begin ex_addr = memf(snap[r]); ex_val = snap[r] + 16'd2; ex_rd = 1; ex_lat = 4; end
            4: begin ex_val = snap[r] - step; ex_addr = ex_val; ex_lat = 3; end
            5: begin ex_val = snap[r] - 16'd2; ex_addr = memf(ex_val); ex_rd = 1; ex_lat = 4; end
            6: begin ex_addr = base + memf(snap[7]); ex_reg = 7; ex_val = pcn; ex_rd = 1; ex_lat = 5; end
            default: begin
                ex_addr = memf(base + memf(snap[7])); ex_reg = 7; ex_val = pcn; ex_rd = 2; ex_lat = 6;
            end
        endcase
        stall_en = stall;
        @(negedge clk);
        wb_cnt = 0; rd_cnt = 0;
        start = 1'b1; mode = 3'(m); reg_sel = 3'(r); byte_op = byt;
        @(posedge clk);
        lat = 0;
        while (lat < 200) begin
            @(negedge clk);
            start = 1'b0;
            lat = lat + 1;
            if (done) break;
        end
        chk(eff_addr == ex_addr, {tag, " address"}, eff_addr, ex_addr);
        chk(is_reg == ex_isreg, {tag, " is_reg"}, is_reg, ex_isreg);
        chk(rd_cnt == ex_rd, {tag, " memory reads"}, rd_cnt, ex_rd);
        if (stall) chk(lat > ex_lat, {tag, " R11 stalled latency"}, lat, ex_lat + 1);
        else       chk(lat == ex_lat, {tag, " R11 latency"}, lat, ex_lat);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R10 done one cycle"}, done, 0);
        chk(eff_addr == ex_addr, {tag, " R10 address held"}, eff_addr, ex_addr);
        chk(wb_cnt == ex_wb, {tag, " R10 write-back count"}, wb_cnt, ex_wb);
        chk(rf[ex_reg] == ex_val, {tag, " register value"}, rf[ex_reg], ex_val);
        stall_en = 1'b0;
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "reset done low", done, 0);
        chk(mem_rd_valid == 1'b0, "reset no read", mem_rd_valid, 0);
        chk(rf_we == 1'b0, "reset no write", rf_we, 0);
    endtask

    task automatic t_direct();
        set_reg(3, 16'h1234);
        run_case(0, 3, 1'b0, 1'b0, "R1 mode0");
        run_case(0, 7, 1'b1, 1'b0, "R1 mode0 pc");
        run_case(1, 3, 1'b0, 1'b0, "R2 mode1");
    endtask

    task automatic t_postinc();
        set_reg(2, 16'h0400);
        run_case(2, 2, 1'b0, 1'b0, "R3 word");
        run_case(2, 2, 1'b1, 1'b0, "R3 byte");
        set_reg(6, 16'h0800);
        run_case(2, 6, 1'b1, 1'b0, "R3 byte sp");
        set_reg(7, 16'h1000);
        run_case(2, 7, 1'b1, 1'b0, "R3 byte pc");
        run_case(3, 2, 1'b1, 1'b0, "R4 byte deferred");
    endtask

    task automatic t_predec();
        set_reg(1, 16'h0201);
        run_case(4, 1, 1'b1, 1'b0, "R5 byte");
        run_case(4, 1, 1'b0, 1'b0, "R5 word");
        run_case(4, 6, 1'b1, 1'b0, "R5 byte sp");
        run_case(5, 1, 1'b1, 1'b0, "R6 deferred");
    endtask

    task automatic t_index();
        set_reg(7, 16'h2000);
        set_reg(4, 16'h0050);
        run_case(6, 4, 1'b0, 1'b0, "R7 index r4");
        run_case(6, 7, 1'b0, 1'b0, "R7 index pc");
        run_case(7, 4, 1'b0, 1'b0, "R8 deferred r4");
        run_case(7, 7, 1'b1, 1'b0, "R8 deferred pc");
    endtask

    task automatic t_wrap();
        set_reg(5, 16'h0000);
        run_case(4, 5, 1'b0, 1'b0, "R9 predec wrap");
        set_reg(5, 16'hFFFF);
        run_case(2, 5, 1'b1, 1'b0, "R9 postinc wrap");
        set_reg(7, 16'hFFFE);
        set_reg(5, 16'hF000);
        run_case(6, 5, 1'b0, 1'b0, "R9 index wrap");
    endtask

    task automatic t_stall();
        set_reg(7, 16'h3000);
        set_reg(2, 16'h0110);
        run_case(7, 2, 1'b0, 1'b1, "R12 stalled deferred");
        run_case(5, 2, 1'b0, 1'b1, "R12 stalled predec");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 16'(i * 16'h0111);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_direct();
        t_postinc();
        t_predec();
        t_index();
        t_wrap();
        t_stall();
        repeat (2) @(negedge clk);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule